// File: doc/BRIEF.md
# Banked Word-Slice Deserializer

This block collects a stream of narrow words into a bank of wide holding registers. Each accepted input word lands in one slice of one register. A slice counter picks the slice and steps on every accepted word. A bank counter picks the register and steps once the slice counter wraps. Every holding register is driven in parallel onto a flat output bus, so downstream logic can take a complete wide value once its bank is full. A one-cycle pulse marks the moment the last slice of the last bank has been written.

A second path reads the same registers back as a stream. It has its own slice and bank counters and presents one slice per transfer. The input stream is never back-pressured: `in_ready` is tied high, because a register slice can always be overwritten. The output stream follows valid/ready rules. `out_valid` rises only when readout is enabled and no input word is offered in that cycle. While `out_valid` is high and `out_ready` is low, the readout position holds. The input always wins a cycle in which both paths are active. The word width, the register width and the bank count are parameters, and the register width must be a whole multiple of the word width.

Top module: `bank_deser`

## Requirements
- R1: A synchronous active-high reset clears every holding register, all four counters and `all_full` to zero.
- R2: An input word accepted with write slice k and write bank g appears, one cycle later, in bits [WORD_W*(k+1)-1 : WORD_W*k] of bank g. Bank g occupies bits [REG_W*(g+1)-1 : REG_W*g] of `bank_flat`, so slice 0 of bank 0 is the lowest field.
- R3: An accepted word changes only its own slice. Every other bit of `bank_flat` holds, and nothing changes in a cycle without an accepted word.
- R4: `wr_slice` steps by one on each accepted word and wraps from SLICES-1 to 0. It holds when no word is accepted.
- R5: `wr_bank` steps only on an accepted word taken while `wr_slice` is SLICES-1, and it wraps from NBANK-1 to 0.
- R6: `all_full` is high for exactly the one cycle after the accepted word that fills slice SLICES-1 of bank NBANK-1. At that point both write counters read 0.
- R7: `out_valid` equals `rd_en` AND NOT `in_valid`. While it is high, `out_word` equals slice `rd_slice` of bank `rd_bank`, and slice 0 is the lowest field.
- R8: The readout counters step only on a transfer (`out_valid` and `out_ready` both high), with the same wrap rules as the write counters. They hold under back-pressure.
- R9: In a cycle with both `in_valid` and `rd_en` high, the write is performed and the readout counters hold.
- R10: `in_ready` is always high; the input stream is never stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input accepted (always 1) |
| in_word | input | WORD_W | Input word |
| rd_en | input | 1 | Enable the readout stream |
| out_valid | output | 1 | Output slice offered |
| out_ready | input | 1 | Downstream takes the output slice |
| out_word | output | WORD_W | Output slice |
| bank_flat | output | NBANK*REG_W | All holding registers, bank 0 lowest |
| wr_slice | output | SW | Write slice counter |
| wr_bank | output | BW | Write bank counter |
| rd_slice | output | SW | Readout slice counter |
| rd_bank | output | BW | Readout bank counter |
| all_full | output | 1 | One-cycle pulse after the last slice of the last bank is written |

## Verification
The hardest case to reach is the double wrap, where the slice counter and the bank counter both roll over on the same word and `all_full` must fire. It happens only once every SLICES*NBANK accepted words. The bench therefore uses a small configuration of three slices and three banks. It drives whole passes through it, with idle gaps, twice in a row. Readout transfers are mixed with back-pressure cycles and with cycles where input competes. This puts the readout wrap and the input-priority rule on both sides of each counter boundary.

// File: rtl/deser_pkg.sv
package deser_pkg;
  // Counter width for a count of n states; never below one bit.
  function automatic int cw(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/deser_walk.sv
// Two-level position counter: inner index steps on each step pulse,
// outer index steps when the inner index wraps.
module deser_walk #(
  parameter int INNER = 8,
  parameter int OUTER = 4,
  parameter int IW    = deser_pkg::cw(INNER),
  parameter int OW    = deser_pkg::cw(OUTER)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [IW-1:0] inner,
  output logic [OW-1:0] outer,
  output logic          at_end
);
  localparam logic [IW-1:0] IN_LAST = IW'(INNER - 1);
  localparam logic [OW-1:0] OUT_LAST = OW'(OUTER - 1);

  logic inner_wrap;
  assign inner_wrap = (inner == IN_LAST);
  assign at_end     = inner_wrap && (outer == OUT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      inner <= '0;
      outer <= '0;
    end else if (step) begin
      if (inner_wrap) begin
        inner <= '0;
        if (outer == OUT_LAST) outer <= '0;
        else                   outer <= outer + 1'b1;
      end else begin
        inner <= inner + 1'b1;
      end
    end
  end

  // R4/R8: inner index steps by one, or holds without a step
  p_inner_step_r4: assert property (@(posedge clk) disable iff (rst)
    (step && inner != IN_LAST) |=> inner == $past(inner) + 1'b1);
  p_inner_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(inner) && $stable(outer));
  p_inner_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (step && inner == IN_LAST) |=> inner == '0);
  // R5: outer index moves only on an inner wrap
  p_outer_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (step && inner != IN_LAST) |=> $stable(outer));
  p_outer_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (step && at_end) |=> outer == '0);
endmodule

// File: rtl/deser_bank.sv
// Holding registers: one flop field per (bank, slice), decoded write.
module deser_bank #(
  parameter int WORD_W = 32,
  parameter int SLICES = 8,
  parameter int NBANK  = 4,
  parameter int SW     = deser_pkg::cw(SLICES),
  parameter int BW     = deser_pkg::cw(NBANK)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             we,
  input  logic [SW-1:0]                    sel_slice,
  input  logic [BW-1:0]                    sel_bank,
  input  logic [WORD_W-1:0]                wdata,
  output logic [NBANK*SLICES*WORD_W-1:0]   flat
);
  localparam int REG_W  = SLICES * WORD_W;
  localparam int FLAT_W = NBANK * REG_W;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic bank_hit;
    assign bank_hit = we && (sel_bank == BW'(g));
    for (genvar k = 0; k < SLICES; k++) begin : g_slice
      logic [WORD_W-1:0] field;
      always_ff @(posedge clk) begin
        if (rst)                                  field <= '0;
        else if (bank_hit && sel_slice == SW'(k)) field <= wdata;
      end
      assign flat[g*REG_W + k*WORD_W +: WORD_W] = field;
    end
  end

  // Checking helpers: position and mask of the addressed slice.
  int                wr_base;
  logic [FLAT_W-1:0] wr_mask;
  assign wr_base = int'(sel_bank) * REG_W + int'(sel_slice) * WORD_W;
  assign wr_mask = {{(FLAT_W-WORD_W){1'b0}}, {WORD_W{1'b1}}} << wr_base;

  // R2: written word shows up in its slice
  p_slice_lands_r2: assert property (@(posedge clk) disable iff (rst)
    we |=> flat[$past(wr_base) +: WORD_W] == $past(wdata));
  // R3: no other bit moves
  p_others_hold_r3: assert property (@(posedge clk) disable iff (rst)
    we |=> ((flat ^ $past(flat)) & ~$past(wr_mask)) == '0);
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(flat));
endmodule

// File: rtl/deser_rdmux.sv
// Readout selector: views the flat bus as an array of words.
module deser_rdmux #(
  parameter int WORD_W = 32,
  parameter int SLICES = 8,
  parameter int NBANK  = 4,
  parameter int SW     = deser_pkg::cw(SLICES),
  parameter int BW     = deser_pkg::cw(NBANK)
) (
  input  logic [NBANK*SLICES*WORD_W-1:0] flat,
  input  logic [SW-1:0]                  sel_slice,
  input  logic [BW-1:0]                  sel_bank,
  output logic [WORD_W-1:0]              word
);
  localparam int NW = NBANK * SLICES;

  logic [WORD_W-1:0] words [NW];
  for (genvar i = 0; i < NW; i++) begin : g_word
    assign words[i] = flat[i*WORD_W +: WORD_W];
  end

  int idx;
  assign idx = int'(sel_bank) * SLICES + int'(sel_slice);

  always_comb begin
    word = '0;
    if (idx < NW) word = words[idx];
  end
endmodule

// File: rtl/bank_deser.sv
module bank_deser #(
  parameter int WORD_W = 32,
  parameter int REG_W  = 256,
  parameter int NBANK  = 4,
  localparam int SLICES = REG_W / WORD_W,
  localparam int SW     = deser_pkg::cw(SLICES),
  localparam int BW     = deser_pkg::cw(NBANK)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [WORD_W-1:0]        in_word,
  input  logic                     rd_en,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [WORD_W-1:0]        out_word,
  output logic [NBANK*REG_W-1:0]   bank_flat,
  output logic [SW-1:0]            wr_slice,
  output logic [BW-1:0]            wr_bank,
  output logic [SW-1:0]            rd_slice,
  output logic [BW-1:0]            rd_bank,
  output logic                     all_full
);
  logic wr_step, rd_step, wr_end, rd_end;

  assign in_ready  = 1'b1;
  assign wr_step   = in_valid;
  assign out_valid = rd_en && !in_valid;
  assign rd_step   = out_valid && out_ready;

  deser_walk #(.INNER(SLICES), .OUTER(NBANK), .IW(SW), .OW(BW)) u_wr_walk (
    .clk(clk), .rst(rst), .step(wr_step),
    .inner(wr_slice), .outer(wr_bank), .at_end(wr_end));

  deser_walk #(.INNER(SLICES), .OUTER(NBANK), .IW(SW), .OW(BW)) u_rd_walk (
    .clk(clk), .rst(rst), .step(rd_step),
    .inner(rd_slice), .outer(rd_bank), .at_end(rd_end));

  deser_bank #(.WORD_W(WORD_W), .SLICES(SLICES), .NBANK(NBANK),
               .SW(SW), .BW(BW)) u_bank (
    .clk(clk), .rst(rst), .we(wr_step),
    .sel_slice(wr_slice), .sel_bank(wr_bank),
    .wdata(in_word), .flat(bank_flat));

  deser_rdmux #(.WORD_W(WORD_W), .SLICES(SLICES), .NBANK(NBANK),
                .SW(SW), .BW(BW)) u_rdmux (
    .flat(bank_flat), .sel_slice(rd_slice), .sel_bank(rd_bank),
    .word(out_word));

  always_ff @(posedge clk) begin
    if (rst) all_full <= 1'b0;
    else     all_full <= wr_step && wr_end;
  end

  // R6: pulse lands with both write counters back at zero
  p_full_at_zero_r6: assert property (@(posedge clk) disable iff (rst)
    all_full |-> (wr_slice == '0 && wr_bank == '0));
  if (SLICES * NBANK > 1) begin : g_pulse_chk
    p_full_single_r6: assert property (@(posedge clk) disable iff (rst)
      all_full |=> !all_full);
  end
  // R9: input wins, readout position frozen
  p_in_priority_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> $stable(rd_slice) && $stable(rd_bank));
  // R8: back-pressure holds the readout position
  p_bp_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> $stable(rd_slice) && $stable(rd_bank));
  // R7: rd_end is only a status of the readout walk; it must match its counters
  p_rd_end_r7: assert property (@(posedge clk) disable iff (rst)
    rd_end |-> (rd_slice == SW'(SLICES-1)));
endmodule

// File: tb/sim_bank_deser.sv
`timescale 1ns/1ps
module sim_bank_deser;
  localparam int WORD_W = 8;
  localparam int REG_W  = 24;
  localparam int NBANK  = 3;
  localparam int S      = REG_W / WORD_W;
  localparam int SW     = deser_pkg::cw(S);
  localparam int BW     = deser_pkg::cw(NBANK);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, rd_en = 1'b0, out_ready = 1'b0;
  logic [WORD_W-1:0] in_word = '0;
  logic in_ready, out_valid, all_full;
  logic [WORD_W-1:0] out_word;
  logic [NBANK*REG_W-1:0] bank_flat;
  logic [SW-1:0] wr_slice, rd_slice;
  logic [BW-1:0] wr_bank, rd_bank;

  always #5 clk = ~clk;

  bank_deser #(.WORD_W(WORD_W), .REG_W(REG_W), .NBANK(NBANK)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .rd_en(rd_en), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word), .bank_flat(bank_flat),
    .wr_slice(wr_slice), .wr_bank(wr_bank), .rd_slice(rd_slice),
    .rd_bank(rd_bank), .all_full(all_full));

  int n_run = 0, n_fail = 0;
  int ews, ewb, ers, erb;
  logic efull;
  logic [WORD_W-1:0] em [NBANK][S];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_state();
    check(wr_slice == SW'(ews), "R4 wr_slice", wr_slice, ews);
    check(wr_bank == BW'(ewb), "R5 wr_bank", wr_bank, ewb);
    check(rd_slice == SW'(ers), "R8 rd_slice", rd_slice, ers);
    check(rd_bank == BW'(erb), "R8 rd_bank", rd_bank, erb);
    check(all_full == efull, "R6 all_full", all_full, efull);
    for (int g = 0; g < NBANK; g++)
      for (int k = 0; k < S; k++)
        check(bank_flat[g*REG_W + k*WORD_W +: WORD_W] == em[g][k],
              "R2/R3 slice content", bank_flat[g*REG_W + k*WORD_W +: WORD_W], em[g][k]);
  endtask

  task automatic model_clear();
    ews = 0; ewb = 0; ers = 0; erb = 0; efull = 1'b0;
    for (int g = 0; g < NBANK; g++)
      for (int k = 0; k < S; k++) em[g][k] = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; rd_en = 1'b0; out_ready = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    model_clear();
    check_state();  // R1
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic cyc(input logic iv, input logic [WORD_W-1:0] d,
                     input logic re, input logic ordy);
    logic xv;
    @(negedge clk);
    in_valid = iv; in_word = d; rd_en = re; out_ready = ordy;
    #1;
    xv = re && !iv;
    check(in_ready == 1'b1, "R10 in_ready", in_ready, 1);
    check(out_valid == xv, "R7/R9 out_valid", out_valid, xv);
    if (xv) check(out_word == em[erb][ers], "R7 out_word", out_word, em[erb][ers]);
    efull = iv && ews == S-1 && ewb == NBANK-1;
    if (iv) begin
      em[ewb][ews] = d;
      if (ews == S-1) begin ews = 0; ewb = (ewb == NBANK-1) ? 0 : ewb + 1; end
      else ews++;
    end
    if (xv && ordy) begin
      if (ers == S-1) begin ers = 0; erb = (erb == NBANK-1) ? 0 : erb + 1; end
      else ers++;
    end
    @(posedge clk); #1;
    check_state();
  endtask

  initial begin
    #2_000_000;
    n_fail++; n_run++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    model_clear();
    do_reset();
    // Two full passes of writes; gaps test hold, pass 1 competes with readout (R9).
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < NBANK*S; i++) begin
        cyc(1'b1, WORD_W'(p*40 + i*7 + 3), p[0], 1'b1);
        if (i % 4 == 3) cyc(1'b0, 8'hEE, 1'b0, 1'b0);
      end
    // Readout with back-pressure, past the wrap (R7, R8).
    for (int i = 0; i < 2*NBANK*S; i++) cyc(1'b0, 8'h00, 1'b1, (i % 3) != 2);
    cyc(1'b0, 8'h00, 1'b0, 1'b1);
    // Input against readout (R9).
    for (int i = 0; i < 4; i++) cyc(1'b1, WORD_W'(200 + i), 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) cyc(1'b0, 8'h00, 1'b1, 1'b1);
    // Mid-run reset (R1).
    do_reset();
    for (int i = 0; i < NBANK*S + 2; i++) cyc(1'b1, WORD_W'(i + 90), 1'b0, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule